// File: doc/BRIEF.md
# Pipeline NOP-Insertion Power Controller

This controller sits between instruction fetch and a simple in-order pipeline. It slows the rate at which instructions are issued while the clock keeps running at its rated frequency. A programmable slowdown factor `m` gives the number of bubble cycles that follow every issued instruction. During those cycles the controller stalls fetch and signals the pipeline to take a NOP. It also drives the power-control outputs for the execution unit, the register file, the data memory and the pipeline registers.

Each accepted instruction therefore takes `m + 1` cycles. The idle units sleep only inside the bubble window. They are woken one cycle before the next instruction can issue, which gives the power switches a fixed margin to recover. The factor is read only when an instruction is accepted, so a change made during a bubble run cannot shorten or lengthen that run. The gating cells, the datapath and the memory arrays sit outside this block.

Top module: `nop_power_ctrl`

## Requirements
- R1: An instruction is accepted in any cycle where `fetch_valid` is 1 and `fetch_stall` is 0. At that moment the effective factor is captured: `slow_factor` if `slow_en` is 1, otherwise 0.
- R2: After an accepted instruction with captured factor m > 0, `fetch_stall` is 1 for exactly the next m cycles and then returns to 0. Each instruction thus occupies m+1 cycles.
- R3: With `slow_en` at 0, or with `slow_factor` at 0, `fetch_stall` stays at 0 and one instruction is accepted per cycle.
- R4: `nop_inject` equals `fetch_stall` in every cycle.
- R5: In every bubble cycle except the last one of its run, the four power outputs take their sleep values: `alu_sleep`=1, `dmem_sleep`=1, `rf_clk_en`=0, `preg_clk_en`=0.
- R6: In the last bubble cycle of a run, and in every cycle without a bubble, all units are awake: `alu_sleep`=0, `dmem_sleep`=0, `rf_clk_en`=1, `preg_clk_en`=1. A run of one bubble (m=1) therefore puts no unit to sleep.
- R7: Changing `slow_factor` or `slow_en` during a bubble run has no effect on the length of that run. The new value applies at the next accepted instruction.
- R8: A synchronous active-low reset clears any run in progress, including one partway through. After the reset edge, `fetch_stall` and `nop_inject` are 0 and all units are awake.
- R9: When `fetch_valid` is 0 outside a run, no bubble is inserted and units stay awake. Dropping `fetch_valid` during a run does not shorten it.
- R10: The power outputs always move together: `alu_sleep` = `dmem_sleep` = NOT `rf_clk_en` = NOT `preg_clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rated-frequency clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_en | input | 1 | Enables slowdown mode |
| slow_factor | input | 4 | Bubble cycles per instruction (m) |
| fetch_valid | input | 1 | Fetch offers an instruction |
| fetch_stall | output | 1 | Holds fetch and the program counter |
| nop_inject | output | 1 | Pipeline takes a NOP this cycle |
| alu_sleep | output | 1 | Execution unit sleep request |
| rf_clk_en | output | 1 | Register file clock enable |
| dmem_sleep | output | 1 | Data memory sleep request |
| preg_clk_en | output | 1 | Pipeline register clock enable |

## Verification
A corrupted bubble counter shows at `fetch_stall` in the first cycle after an accepted instruction. It appears either as a run of the wrong length or as a stall when the slowdown is off. A wrong value in the registered power state shows in the same cycle as a sleep request in the wake-up cycle, or outside a run, or as outputs that disagree with one another. The directed scenarios check every cycle of runs of length 1, 2, 5 and 15. They also cover a factor change in mid-run and a reset in mid-run, so any of these faults is seen within one instruction period.

// File: rtl/nop_power_pkg.sv
// Shared types for the NOP-insertion power controller.
// Assumes: one registered power-control word drives all four unit controls.
package nop_power_pkg;

    // Power-control word, one field per controlled unit.
    typedef struct packed {
        logic alu_sleep;
        logic rf_clk_en;
        logic dmem_sleep;
        logic preg_clk_en;
    } pwr_ctl_t;

    // Builds the control word for the asleep or the awake state.
    function automatic pwr_ctl_t pwr_word(input logic doze);
        pwr_ctl_t w;
        w.alu_sleep   = doze;
        w.rf_clk_en   = ~doze;
        w.dmem_sleep  = doze;
        w.preg_clk_en = ~doze;
        return w;
    endfunction

endpackage

// File: rtl/nop_bubble_ctr.sv
// Bubble down-counter. It loads the effective slowdown factor when an
// instruction is accepted and counts one step per bubble cycle.
// Assumes: the factor is read only while the count is zero.
module nop_bubble_ctr #(
    parameter int FACTOR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slow_en,
    input  logic [FACTOR_W-1:0] factor,
    input  logic                fetch_valid,
    output logic [FACTOR_W-1:0] cnt_q,
    output logic [FACTOR_W-1:0] cnt_d
);

    logic accept;

    // Next-count logic: load on accept, otherwise count down to zero.
    always_comb begin
        accept = fetch_valid && (cnt_q == '0);
        if (accept)
            cnt_d = slow_en ? factor : '0;
        else if (cnt_q != '0)
            cnt_d = cnt_q - FACTOR_W'(1);
        else
            cnt_d = '0;
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/nop_pwr_seq.sv
// Registered power sequencer. It requests sleep while more than WAKE_LEAD
// bubble cycles remain, so units wake WAKE_LEAD cycles before the next issue.
// Assumes: cnt_d is the count the bubble counter holds in the next cycle.
module nop_pwr_seq
    import nop_power_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int WAKE_LEAD = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d,
    output pwr_ctl_t         pwr_q
);

    logic doze_d;

    // Sleep decision for the next cycle; the variant depends on the wake margin.
    generate
        if (WAKE_LEAD == 0) begin : g_no_margin
            always_comb doze_d = (cnt_d != '0);
        end else begin : g_margin
            always_comb doze_d = (cnt_d > CNT_W'(WAKE_LEAD));
        end
    endgenerate

    // Power-control register; reset leaves every unit awake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_q <= pwr_word(1'b0);
        else
            pwr_q <= pwr_word(doze_d);
    end

endmodule

// File: rtl/nop_power_ctrl.sv
// NOP-insertion power controller top. It stretches each instruction to m+1
// cycles by stalling fetch and injecting NOPs, and sleeps idle units in the
// bubble window with a one-cycle wake-up margin.
// Assumes: the clock always runs at the rated frequency; fetch holds its
// instruction while fetch_stall is high.
module nop_power_ctrl
    import nop_power_pkg::*;
#(
    parameter int FACTOR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slow_en,
    input  logic [FACTOR_W-1:0] slow_factor,
    input  logic                fetch_valid,
    output logic                fetch_stall,
    output logic                nop_inject,
    output logic                alu_sleep,
    output logic                rf_clk_en,
    output logic                dmem_sleep,
    output logic                preg_clk_en
);

    localparam int WAKE_MARGIN = 1;

    logic [FACTOR_W-1:0] cnt_q;
    logic [FACTOR_W-1:0] cnt_d;
    pwr_ctl_t            pwr_q;

    nop_bubble_ctr #(.FACTOR_W(FACTOR_W)) ctr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_en     (slow_en),
        .factor      (slow_factor),
        .fetch_valid (fetch_valid),
        .cnt_q       (cnt_q),
        .cnt_d       (cnt_d)
    );

    nop_pwr_seq #(.CNT_W(FACTOR_W), .WAKE_LEAD(WAKE_MARGIN)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_d (cnt_d),
        .pwr_q (pwr_q)
    );

    // Stall and NOP injection mark every cycle with bubbles still pending.
    always_comb begin
        fetch_stall = (cnt_q != '0);
        nop_inject  = fetch_stall;
    end

    // Fan the registered power word out to the unit controls.
    always_comb begin
        alu_sleep   = pwr_q.alu_sleep;
        rf_clk_en   = pwr_q.rf_clk_en;
        dmem_sleep  = pwr_q.dmem_sleep;
        preg_clk_en = pwr_q.preg_clk_en;
    end

endmodule

// File: rtl/nop_power_ctrl_chk.sv
// Port-level property checker for nop_power_ctrl, attached by bind.
// Assumes: the same clock and synchronous active-low reset as the design.
module nop_power_ctrl_chk #(
    parameter int FACTOR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                slow_en,
    input logic [FACTOR_W-1:0] slow_factor,
    input logic                fetch_valid,
    input logic                fetch_stall,
    input logic                nop_inject,
    input logic                alu_sleep,
    input logic                rf_clk_en,
    input logic                dmem_sleep,
    input logic                preg_clk_en
);

    logic accept;
    assign accept = fetch_valid && !fetch_stall;

    // R4: the inject line marks exactly the stalled cycles.
    p_inject_tracks_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nop_inject == fetch_stall);

    // R10: all four power outputs agree.
    p_power_coherent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_sleep == dmem_sleep) && (rf_clk_en == !alu_sleep) && (preg_clk_en == !alu_sleep));

    // R5 and R6: sleep only inside a run, and never in its last cycle.
    p_sleep_inside_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alu_sleep |-> fetch_stall);
    p_sleep_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alu_sleep |=> fetch_stall);

    // R2: a nonzero effective factor starts a run in the next cycle.
    p_run_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && slow_en && (slow_factor != '0)) |=> fetch_stall);

    // R3: no bubble follows an accept when the slowdown is off or zero.
    p_no_run_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (!slow_en || (slow_factor == '0))) |=> !fetch_stall);

    // R8: the cycle after a reset edge is idle and awake.
    p_reset_idle_r8: assert property (@(posedge clk)
        !rst_n |=> (!fetch_stall && !nop_inject && !alu_sleep && rf_clk_en && !dmem_sleep && preg_clk_en));

endmodule

bind nop_power_ctrl nop_power_ctrl_chk #(.FACTOR_W(FACTOR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_en     (slow_en),
    .slow_factor (slow_factor),
    .fetch_valid (fetch_valid),
    .fetch_stall (fetch_stall),
    .nop_inject  (nop_inject),
    .alu_sleep   (alu_sleep),
    .rf_clk_en   (rf_clk_en),
    .dmem_sleep  (dmem_sleep),
    .preg_clk_en (preg_clk_en)
);

// File: tb/nop_power_ctrl_tb_top.sv
// Directed bench for nop_power_ctrl: one task per scenario, each checking
// its own cycles. Inputs change at the falling edge, outputs are read 1 ns later.
module nop_power_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       slow_en;
    logic [3:0] slow_factor;
    logic       fetch_valid;
    logic       fetch_stall;
    logic       nop_inject;
    logic       alu_sleep;
    logic       rf_clk_en;
    logic       dmem_sleep;
    logic       preg_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    nop_power_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_en     (slow_en),
        .slow_factor (slow_factor),
        .fetch_valid (fetch_valid),
        .fetch_stall (fetch_stall),
        .nop_inject  (nop_inject),
        .alu_sleep   (alu_sleep),
        .rf_clk_en   (rf_clk_en),
        .dmem_sleep  (dmem_sleep),
        .preg_clk_en (preg_clk_en)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Checks every output against the expected stall and sleep state.
    task automatic chk_cycle(input string tag, input logic exp_stall, input logic exp_doze);
        chk({tag, " stall"},  fetch_stall, exp_stall);
        chk({tag, " inject R4"}, nop_inject, exp_stall);
        chk({tag, " alu"},    alu_sleep,   exp_doze);
        chk({tag, " rf R10"}, rf_clk_en,   !exp_doze);
        chk({tag, " dmem"},   dmem_sleep,  exp_doze);
        chk({tag, " preg"},   preg_clk_en, !exp_doze);
    endtask

    // R1 R2 R5 R6: one accepted instruction followed by its full run of m bubbles.
    task automatic t_run(input int m, input string tag);
        slow_en = 1'b1; slow_factor = 4'(m); fetch_valid = 1'b1;
        #1 chk_cycle({tag, " accept R1"}, 1'b0, 1'b0);
        @(negedge clk);
        for (int k = 1; k <= m; k++) begin
            #1 chk_cycle({tag, (k < m) ? " bubble R5" : " last R6"}, 1'b1, k < m);
            @(negedge clk);
        end
        fetch_valid = 1'b0;
        #1 chk_cycle({tag, " after R2"}, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    // R3: slowdown off, or a zero factor, gives back-to-back issue.
    task automatic t_full_rate();
        fetch_valid = 1'b1; slow_en = 1'b0; slow_factor = 4'd9;
        for (int k = 0; k < 4; k++) begin
            #1 chk_cycle("off R3", 1'b0, 1'b0);
            @(negedge clk);
        end
        slow_en = 1'b1; slow_factor = 4'd0;
        for (int k = 0; k < 4; k++) begin
            #1 chk_cycle("zero R3", 1'b0, 1'b0);
            @(negedge clk);
        end
        fetch_valid = 1'b0;
        @(negedge clk);
    endtask

    // R7 R9: factor, enable and fetch_valid change during a run of 3.
    task automatic t_midrun_change();
        fetch_valid = 1'b0; slow_en = 1'b1; slow_factor = 4'd7;
        for (int k = 0; k < 3; k++) begin
            #1 chk_cycle("idle R9", 1'b0, 1'b0);
            @(negedge clk);
        end
        slow_factor = 4'd3; fetch_valid = 1'b1;
        @(negedge clk);
        slow_factor = 4'd1; slow_en = 1'b0; fetch_valid = 1'b0;
        #1 chk_cycle("chg b1 R7", 1'b1, 1'b1);
        @(negedge clk);
        slow_en = 1'b1; fetch_valid = 1'b1;
        #1 chk_cycle("chg b2 R9", 1'b1, 1'b1);
        @(negedge clk);
        #1 chk_cycle("chg b3 R7", 1'b1, 1'b0);
        @(negedge clk);
        #1 chk_cycle("new accept R7", 1'b0, 1'b0);
        @(negedge clk);
        #1 chk_cycle("new factor R7", 1'b1, 1'b0);
        @(negedge clk);
        fetch_valid = 1'b0;
        #1 chk_cycle("new end R7", 1'b0, 1'b0);
        @(negedge clk);
    endtask

    // R8: reset in the middle of a run of 6.
    task automatic t_midrun_reset();
        slow_en = 1'b1; slow_factor = 4'd6; fetch_valid = 1'b1;
        @(negedge clk);
        fetch_valid = 1'b0;
        #1 chk_cycle("pre-rst R5", 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1 chk_cycle("mid rst R8", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk_cycle("post rst R8", 1'b0, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; slow_en = 1'b0; slow_factor = 4'd0; fetch_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk_cycle("reset R8", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        t_full_rate();
        t_run(1, "m1");
        t_run(2, "m2");
        t_run(5, "m5");
        t_run(15, "m15");
        t_midrun_change();
        t_midrun_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule